// File: doc/BRIEF.md
# Display Configuration Shadow Bank with Frame-Synchronous Commit

This block holds the configuration registers of a display engine in two copies. Software writes only into a shadow copy over a simple 32-bit register bus. The active copy drives the datapath. It is refreshed from the shadow copy in one step, at the start of a vertical blanking interval, so a frame is never drawn with a half-updated configuration.

A control word at byte offset 0 selects between two policies. With automatic reload on, which is the reset state, every vblank pulse copies the whole shadow bank to the active bank. With automatic reload off, software requests a single copy by setting a load bit. The copy then happens at the next vblank pulse, and the load bit clears itself. Software polls the load bit before it starts the next batch of writes.

Configuration register `i` (0-based) sits at byte offset `4*(i+1)`. The two low address bits are ignored.

Top module: `cfg_shadow_bank`

## Requirements
- R1: During and after a synchronous reset, every shadow register, every active register, the load bit and the reload-disable bit are 0, and `bus_rdata` is 0.
- R2: A write to configuration offset `4*(i+1)` stores the data in shadow register `i` only. A read of that offset returns the shadow value in `bus_rdata` one cycle after `bus_re`, even when the active value differs.
- R3: With the reload-disable bit (control bit 1) at 0, each cycle with `vblank_i` high copies all shadow registers to `active_o`, visible on the cycle after the pulse. Between pulses `active_o` does not change.
- R4: With the reload-disable bit at 1 and no request pending, a vblank pulse leaves `active_o` unchanged.
- R5: Writing the control word with bit 0 = 1 and bit 1 = 1 raises a pending request. `active_o` keeps its old value until the next vblank pulse. That pulse copies the shadow bank and clears the request.
- R6: A read of offset 0 returns the pending request in bit 0 and the reload-disable bit in bit 1, with all other bits 0.
- R7: Shadow writes made while a request is pending are part of the copy that the request performs.
- R8: Each copy takes the shadow contents as they stood before the clock edge of the vblank pulse. A shadow write in that same cycle is left for a later copy. A request written in that same cycle stays pending for the following pulse.
- R9: A control write with bit 1 = 0 drops any pending request and returns to automatic reload. A control write with bit 1 = 1 and bit 0 = 0 neither raises nor cancels a request.
- R10: Reads of word offsets above the last configuration register return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data valid next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| vblank_i | input | 1 | One-cycle pulse at the start of vertical blanking |
| active_o | output | NUM_REGS*DATA_W | Active bank, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest situation to reach is a collision on one clock edge: a vblank pulse in the same cycle as a shadow write or a new load request, while an older request is pending. Directed sequences build these collisions one at a time. They first arm a request, then fire the pulse together with a write, then fire it together with a fresh request. A seeded random phase then mixes bus traffic, control writes and pulses at a high rate, so pending requests overlap with pulses often, and a cycle-level bench model predicts every read and the whole active bank after every cycle.

// File: rtl/cfg_shadow_bank_pkg.sv
package cfg_shadow_bank_pkg;
  localparam int CTRL_LOAD_BIT   = 0;
  localparam int CTRL_NOAUTO_BIT = 1;

  typedef struct packed {
    logic noauto;
    logic pending;
  } ctrl_state_t;
endpackage

// File: rtl/cfg_shadow_bank_decode.sv
module cfg_shadow_bank_decode #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_cfg,
  output logic [IDX_W-1:0]  idx
);
  logic [WORD_W-1:0] word;

  assign word     = addr[ADDR_W-1:2];
  assign hit_ctrl = (word == '0);
  assign hit_cfg  = (word != '0) && (word <= WORD_W'(NUM_REGS));
  assign idx      = IDX_W'(word - WORD_W'(1));
endmodule

// File: rtl/cfg_shadow_bank_loadctl.sv
module cfg_shadow_bank_loadctl
  import cfg_shadow_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        wr_load,
  input  logic        wr_noauto,
  input  logic        vblank,
  output ctrl_state_t state_o,
  output logic        load_o
);
  ctrl_state_t st_q;

  assign load_o  = vblank && (st_q.pending || !st_q.noauto);
  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (ctrl_we) st_q.noauto <= wr_noauto;
      if (ctrl_we && !wr_noauto)     st_q.pending <= 1'b0;
      else if (ctrl_we && wr_load)   st_q.pending <= 1'b1;
      else if (load_o)               st_q.pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_shadow_bank_regs.sv
module cfg_shadow_bank_regs #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       load,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_shadow,
  output logic [NUM_REGS*DATA_W-1:0] active_o
);
  logic [DATA_W-1:0] shadow_q [NUM_REGS];
  logic [DATA_W-1:0] active_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        shadow_q[i] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active_q[i] <= '0;
      end else if (load) begin
        active_q[i] <= shadow_q[i];
      end
    end

    assign active_o[i*DATA_W +: DATA_W] = active_q[i];
  end

  assign rd_shadow = shadow_q[rd_idx];
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_shadow_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       vblank_i,
  output logic [NUM_REGS*DATA_W-1:0] active_o
);
  logic              hit_ctrl, hit_cfg, load;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_shadow;
  ctrl_state_t       ctrl_st;
  logic              pend_q, noauto_q;

  cfg_shadow_bank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_cfg(hit_cfg), .idx(idx)
  );

  cfg_shadow_bank_loadctl u_ctl (
    .clk(clk), .rst(rst),
    .ctrl_we(bus_we && hit_ctrl),
    .wr_load(bus_wdata[CTRL_LOAD_BIT]),
    .wr_noauto(bus_wdata[CTRL_NOAUTO_BIT]),
    .vblank(vblank_i),
    .state_o(ctrl_st), .load_o(load)
  );

  assign pend_q   = ctrl_st.pending;
  assign noauto_q = ctrl_st.noauto;

  cfg_shadow_bank_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && hit_cfg), .wr_idx(idx), .wr_data(bus_wdata),
    .load(load), .rd_idx(idx), .rd_shadow(rd_shadow), .active_o(active_o)
  );

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_LOAD_BIT]   = pend_q;
    ctrl_word[CTRL_NOAUTO_BIT] = noauto_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (hit_ctrl)     bus_rdata <= ctrl_word;
      else if (hit_cfg) bus_rdata <= rd_shadow;
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_we,
  input logic                       bus_re,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       vblank_i,
  input logic [NUM_REGS*DATA_W-1:0] active_o,
  input logic                       pend,
  input logic                       noauto
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (active_o == '0 && !pend && !noauto && bus_rdata == '0)); // R1

  AST_ACTIVE_ONLY_AT_VBLANK: assert property (@(posedge clk) disable iff (rst)
    !vblank_i |=> $stable(active_o)); // R3

  AST_IDLE_VBLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (vblank_i && !pend && noauto) |=> $stable(active_o)); // R4

  AST_PEND_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> ($past(vblank_i) || $past(bus_we))); // R5

  AST_PEND_NEEDS_NOAUTO: assert property (@(posedge clk) disable iff (rst)
    pend |-> noauto); // R9

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (int'(bus_addr[ADDR_W-1:2]) > NUM_REGS)) |=> (bus_rdata == '0)); // R10
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .vblank_i(vblank_i), .active_o(active_o),
  .pend(pend_q), .noauto(noauto_q)
);

// File: tb/cfg_shadow_bank_tb.sv
module cfg_shadow_bank_tb;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 8;
  typedef logic [NR*DW-1:0] wide_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0, vblank_i = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  wide_t active_o;

  always #4 clk = ~clk;

  cfg_shadow_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank_i(vblank_i),
    .active_o(active_o)
  );

  int n_chk = 0, n_fail = 0;
  bit reported = 0;
  logic [DW-1:0] m_sh [NR];
  logic [DW-1:0] m_act [NR];
  logic m_pend = 1'b0, m_noauto = 1'b0;

  function automatic logic [AW-1:0] cfg_a(int i);
    return AW'((i + 1) * 4);
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    int w = int'(a[AW-1:2]);
    if (w == 0) return DW'({m_noauto, m_pend});
    if (w <= NR) return m_sh[w-1];
    return '0;
  endfunction

  function automatic wide_t exp_act();
    wide_t r;
    for (int i = 0; i < NR; i++) r[i*DW +: DW] = m_act[i];
    return r;
  endfunction

  task automatic check(string req, wide_t act, wide_t exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic cyc(bit we, bit re, logic [AW-1:0] a, logic [DW-1:0] d, bit vb, string req);
    logic [DW-1:0] e;
    bit ld;
    int w;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; vblank_i = vb;
    e  = exp_rd(a);
    w  = int'(a[AW-1:2]);
    ld = vb && (m_pend || !m_noauto);
    @(posedge clk);
    if (ld) for (int i = 0; i < NR; i++) m_act[i] = m_sh[i];
    if (we && w >= 1 && w <= NR) m_sh[w-1] = d;
    if (we && w == 0) begin
      if (!d[1])    m_pend = 1'b0;
      else if (d[0]) m_pend = 1'b1;
      else if (ld)  m_pend = 1'b0;
      m_noauto = d[1];
    end else if (ld) m_pend = 1'b0;
    @(negedge clk);
    bus_we = 0; bus_re = 0; vblank_i = 0;
    if (re) check(req, wide_t'(bus_rdata), wide_t'(e));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d); cyc(1, 0, a, d, 0, ""); endtask
  task automatic rd(logic [AW-1:0] a, string req); cyc(0, 1, a, '0, 0, req); endtask
  task automatic vbl(); cyc(0, 0, '0, '0, 1, ""); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] keep0;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    repeat (4) @(negedge clk);
    check("R1 active after reset", active_o, '0);
    check("R1 rdata after reset", wide_t'(bus_rdata), '0);
    rst = 1'b0;
    rd('0, "R1 ctrl after reset");
    rd(cfg_a(3), "R1 shadow after reset");

    // R3: autoload default, copy on every vblank
    for (int i = 0; i < NR; i++) wr(cfg_a(i), $urandom);
    check("R3 active waits for vblank", active_o, '0);
    vbl();
    check("R3 copy at vblank", active_o, exp_act());
    // R2: shadow readback differs from active
    wr(cfg_a(2), 32'hDEAD_0002);
    rd(cfg_a(2), "R2 read returns shadow");
    check("R2 active untouched by write", active_o, exp_act());
    vbl();
    check("R3 second vblank copy", active_o, exp_act());

    // R4: autoload off, no request
    wr('0, 32'h2);
    wr(cfg_a(5), 32'h5555_AAAA);
    vbl();
    check("R4 idle vblank holds", active_o, exp_act());
    rd('0, "R6 ctrl noauto only");

    // R5/R6/R7: commit request
    wr('0, 32'h3);
    rd('0, "R6 pending visible");
    check("R5 active held while pending", active_o, exp_act());
    wr(cfg_a(7), 32'h7777_0007);
    vbl();
    check("R7 late write in transfer", wide_t'(active_o[7*DW +: DW]), wide_t'(32'h7777_0007));
    check("R5 transfer at vblank", active_o, exp_act());
    rd('0, "R6 pending self-cleared");

    // R8: collisions at vblank edge
    wr('0, 32'h3);
    keep0 = m_sh[0];
    cyc(1, 0, cfg_a(0), 32'hC011_1DE0, 1, "");
    check("R8 same-cycle write excluded", wide_t'(active_o[0 +: DW]), wide_t'(keep0));
    cyc(1, 0, '0, 32'h3, 1, "");
    check("R8 idle-state vblank with new request", active_o, exp_act());
    rd('0, "R8 request survives same-cycle vblank");
    vbl();
    check("R8 request served next vblank", wide_t'(active_o[0 +: DW]), wide_t'(32'hC011_1DE0));

    // R9: control write corner cases
    wr('0, 32'h3);
    wr('0, 32'h2);
    rd('0, "R9 bit0 clear does not cancel");
    wr('0, 32'h0);
    rd('0, "R9 bit1 clear drops request");
    wr('0, 32'h1);
    rd('0, "R9 load bit ignored with autoload on");

    // R10: out of range
    wr(AW'((NR + 1) * 4), 32'hBAD0_BAD0);
    wr(AW'(8'hFC), 32'hBAD1_BAD1);
    rd(AW'((NR + 1) * 4), "R10 oor read zero");
    rd(AW'(8'hFC), "R10 top address read zero");
    for (int i = 0; i < NR; i++) rd(cfg_a(i), "R10 shadow untouched by oor write");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      logic [AW-1:0] a;
      if (sel < 2)      a = '0;
      else if (sel < 9) a = cfg_a($urandom_range(0, NR - 1));
      else              a = AW'($urandom_range(NR + 1, 63) * 4);
      if (a == '0 && $urandom_range(0, 1) == 1)
        cyc(0, 1, a, '0, $urandom_range(0, 3) == 0, "R6 random ctrl read");
      else if ($urandom_range(0, 1) == 1)
        cyc(1, 0, a, (a == '0) ? DW'($urandom_range(0, 3)) : DW'($urandom),
            $urandom_range(0, 3) == 0, "");
      else
        cyc(0, 1, a, '0, $urandom_range(0, 3) == 0, "R2 random read");
      check("R3 random active bank", active_o, exp_act());
    end

    report();
    $finish;
  end
endmodule